// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block gathers single-cycle error pulses from a cell-receive datapath into sticky status bits and turns them into one active-low interrupt line. Each captured bit is held until software reads the status byte. The read is signalled by a one-cycle strobe. That read returns the captured set, clears it and releases the interrupt. A per-source enable mask and a global enable decide which captured bits can pull the line low. A restriction mode limits signalling to the three receive-cell error classes. The bus decoding and the error detectors sit outside the block.

Sources occupy status bits 0 to 7. Bits 0, 1 and 2 are the receive-cell error classes: bad header checksum, short cell (fewer than 53 bytes) and received symbol error. Bits 3 to 7 are other sources. In the control byte, bit 0 is the global interrupt enable and bit 5 selects the receive-cell-only mode. Normal operation uses bit 0 set and bit 5 clear.

Top module: `isc_top`

## Requirements
- R1: After reset the status byte reads 0x00 and the interrupt output is high (inactive).
- R2: A one-cycle pulse on event bit i sets status bit i on the next clock edge, and the bit stays set after the pulse ends until a status read clears it.
- R3: Status bits record events whatever the mask and control values; masking and enables affect only the interrupt output.
- R4: With control bit 0 set, control bit 5 clear and mask bit i set to 1, a captured event on source i drives the interrupt low on the same clock edge that sets the status bit.
- R5: While control bit 0 is 0, the interrupt output stays high.
- R6: A source whose mask bit is 0 cannot drive the interrupt low. Setting that mask bit later while the status bit is still pending drives the interrupt low on the next edge.
- R7: While control bit 5 is 1, only status bits 0, 1 and 2 can drive the interrupt low. Pending bits 3 to 7 are ignored for signalling.
- R8: A status-read strobe clears every status bit on the next edge and returns the interrupt output high, unless a new event arrives.
- R9: An event that arrives in the same cycle as the status-read strobe is left set after the clear, and it signals under the usual enable rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, already synchronized to clk |
| evt_i | input | 8 | One-cycle event pulses; bits 0 to 2 are receive-cell errors |
| irq_mask_i | input | 8 | Per-source interrupt enable (1 = may signal) |
| ctrl_i | input | 8 | Control byte: bit 0 global enable, bit 5 receive-cell-only mode |
| stat_rd_i | input | 1 | One-cycle status-read strobe; clears status at the edge |
| stat_o | output | 8 | Current sticky status byte |
| irq_n_o | output | 1 | Interrupt output, active low |

## Verification
On every cycle the assertions check four properties. Captured bits persist when there is no read. The status after a read equals exactly the events of that cycle. A disabled global enable keeps the line high. In restriction mode a low line is always backed by a pending, enabled receive-cell bit. The bench scenarios cover the properties that involve several steps. These are the reset state, status bits that still hold under a zero mask, and a late unmask that raises a pending interrupt. They also cover the collision of a read with a new event, and the release of the line after a clearing read.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int SRC_W          = 8;
  localparam int CTRL_W         = 8;
  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_RXONLY_BIT = 5;
  // receive-cell error classes: checksum, short cell, symbol error
  localparam logic [SRC_W-1:0] RX_CELL_SET = 8'h07;
endpackage

// File: rtl/isc_sticky_bank.sv
module isc_sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_q_o,
  output logic [W-1:0] stat_d_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] stat_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      // new event wins over a simultaneous clear
      stat_d[i] = evt_i[i] | (stat_q[i] & ~clr_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stat_q[i] <= 1'b0;
      end else if (evt_i[i] || clr_i) begin
        stat_q[i] <= stat_d[i];
      end
    end
  end

  assign stat_q_o = stat_q;
  assign stat_d_o = stat_d;
endmodule

// File: rtl/isc_irq_gate.sv
module isc_irq_gate #(
  parameter int                W      = 8,
  parameter logic [W-1:0]      RX_SET = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pend_d_i,
  input  logic [W-1:0] mask_i,
  input  logic         glb_en_i,
  input  logic         rx_only_i,
  output logic         irq_n_o
);
  logic [W-1:0] class_sel;
  logic [W-1:0] live;
  logic         irq_d;
  logic         irq_q;

  always_comb begin
    class_sel = rx_only_i ? RX_SET : {W{1'b1}};
    live      = pend_d_i & mask_i & class_sel;
    irq_d     = glb_en_i & (|live);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_n_o = ~irq_q;
endmodule

// File: rtl/isc_top.sv
module isc_top
  import isc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SRC_W-1:0]  evt_i,
  input  logic [SRC_W-1:0]  irq_mask_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic              stat_rd_i,
  output logic [SRC_W-1:0]  stat_o,
  output logic              irq_n_o
);
  logic [SRC_W-1:0] stat_q;
  logic [SRC_W-1:0] stat_d;

  isc_sticky_bank #(.W(SRC_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_i    (evt_i),
    .clr_i    (stat_rd_i),
    .stat_q_o (stat_q),
    .stat_d_o (stat_d)
  );

  isc_irq_gate #(.W(SRC_W), .RX_SET(RX_CELL_SET)) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend_d_i  (stat_d),
    .mask_i    (irq_mask_i),
    .glb_en_i  (ctrl_i[CTRL_EN_BIT]),
    .rx_only_i (ctrl_i[CTRL_RXONLY_BIT]),
    .irq_n_o   (irq_n_o)
  );

  assign stat_o = stat_q;
endmodule

// File: rtl/isc_checker.sv
module isc_checker
  import isc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [SRC_W-1:0]  evt_i,
  input logic [SRC_W-1:0]  irq_mask_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic              stat_rd_i,
  input logic [SRC_W-1:0]  stat_o,
  input logic              irq_n_o
);
  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((stat_o & $past(evt_i)) == $past(evt_i)));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rd_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd_i |=> (stat_o == $past(evt_i)));

  // R5
  glb_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_i[CTRL_EN_BIT] |=> irq_n_o);

  // R7
  rx_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_i[CTRL_RXONLY_BIT] |=>
      (irq_n_o || (|(stat_o & RX_CELL_SET & $past(irq_mask_i)))));

  // R4
  raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_i[CTRL_EN_BIT] && !ctrl_i[CTRL_RXONLY_BIT] && (|(evt_i & irq_mask_i)))
      |=> !irq_n_o);
endmodule

bind isc_top isc_checker u_isc_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_i      (evt_i),
  .irq_mask_i (irq_mask_i),
  .ctrl_i     (ctrl_i),
  .stat_rd_i  (stat_rd_i),
  .stat_o     (stat_o),
  .irq_n_o    (irq_n_o)
);

// File: tb/isc_top_tb_top.sv
module isc_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic [7:0] evt;
  logic [7:0] mask;
  logic [7:0] ctrl;
  logic       rd;
  logic [7:0] stat;
  logic       irq_n;

  int n_chk;
  int n_err;
  bit done;

  isc_top dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt),
    .irq_mask_i (mask),
    .ctrl_i     (ctrl),
    .stat_rd_i  (rd),
    .stat_o     (stat),
    .irq_n_o    (irq_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] e);
    evt = e;
    tick();
    evt = 8'h00;
  endtask

  task automatic do_read();
    rd = 1'b1;
    tick();
    rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 status", stat, 8'h00);
    chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_capture_masked();
    ctrl = 8'h00; mask = 8'h00;
    pulse(8'h48);
    chk("R2 capture", stat, 8'h48);
    tick(); tick(); tick();
    chk("R2 hold", stat, 8'h48);
    chk("R3 status ignores mask", stat, 8'h48);
    chk("R5 irq off", {7'b0, irq_n}, 8'h01);
    do_read();
    chk("R8 clear", stat, 8'h00);
  endtask

  task automatic t_enable();
    ctrl = 8'h01; mask = 8'hFF;
    pulse(8'h10);
    chk("R4 irq low", {7'b0, irq_n}, 8'h00);
    chk("R4 status", stat, 8'h10);
    tick();
    chk("R4 irq held", {7'b0, irq_n}, 8'h00);
    do_read();
    chk("R8 status cleared", stat, 8'h00);
    chk("R8 irq released", {7'b0, irq_n}, 8'h01);
    ctrl = 8'h00;
    pulse(8'h01);
    chk("R5 disabled irq", {7'b0, irq_n}, 8'h01);
    chk("R3 status when disabled", stat, 8'h01);
    do_read();
  endtask

  task automatic t_mask();
    ctrl = 8'h01; mask = 8'hFE;
    pulse(8'h01);
    chk("R6 masked source", {7'b0, irq_n}, 8'h01);
    mask = 8'hFF;
    tick();
    chk("R6 late unmask", {7'b0, irq_n}, 8'h00);
    do_read();
    chk("R8 irq released", {7'b0, irq_n}, 8'h01);
  endtask

  task automatic t_rx_only();
    ctrl = 8'h21; mask = 8'hFF;
    pulse(8'hF8);
    chk("R7 non-cell ignored", {7'b0, irq_n}, 8'h01);
    chk("R7 status kept", stat, 8'hF8);
    pulse(8'h04);
    chk("R7 cell error signals", {7'b0, irq_n}, 8'h00);
    do_read();
    chk("R7 cleared", {7'b0, irq_n}, 8'h01);
    pulse(8'h02);
    chk("R7 short cell signals", {7'b0, irq_n}, 8'h00);
    do_read();
    ctrl = 8'h01;
  endtask

  task automatic t_collide();
    ctrl = 8'h01; mask = 8'hFF;
    pulse(8'h02);
    rd = 1'b1; evt = 8'h80;
    tick();
    rd = 1'b0; evt = 8'h00;
    chk("R9 new event kept", stat, 8'h80);
    chk("R9 irq still low", {7'b0, irq_n}, 8'h00);
    do_read();
    chk("R9 later clear", stat, 8'h00);
    chk("R9 irq released", {7'b0, irq_n}, 8'h01);
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 0;
    rst_n = 1'b0; evt = 8'h00; mask = 8'hFF; ctrl = 8'h01; rd = 1'b0;
    tick(); tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_capture_masked();
    t_enable();
    t_mask();
    t_rx_only();
    t_collide();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule